// File: doc/BRIEF.md
# Sign-Magnitude Stereo PCM Mixer

This block mixes eight PCM voices into one stereo sample. A sequencer outside the block presents the voices one per slot. Each slot carries an 8-bit sample, the voice's 8-bit envelope and its 8-bit pan value, and says whether the voice is enabled.

The sample is in sign-magnitude form. Bits 6..0 hold the magnitude and bit 7 is the sign; a set sign bit means the value is positive. The block multiplies the signed magnitude by the envelope. It then multiplies that product by two 4-bit gains taken from the pan value, and divides each result by 32, rounding toward minus infinity. This gives a left and a right contribution. Both are added, with saturation, into 16-bit signed running sums.

The block keeps its own slot counter. When that counter wraps after the eighth slot, the block emits the finished stereo pair with a one-cycle strobe and restarts both sums from zero. A sounding flag, set and cleared through a write port, gates all mixing. Writing the flag to zero also empties the sums.

Top module: `pcm_stereo_mixer`

## Requirements
- R1: A sample with bit 7 set has the value +bits[6:0]. A sample with bit 7 clear has the value −bits[6:0].
- R2: The scaled value is the signed sample value times the envelope, read as unsigned 0..255.
- R3: The left contribution is floor(scaled × pan[7:4] / 32). The right contribution is floor(scaled × pan[3:0] / 32).
- R4: The slot counter starts at 0, counts every slot_valid cycle and wraps from 7 to 0. The eighth slot of a frame is the last slot. Two rising edges after that slot is taken, mix_valid is high for exactly one cycle. mix_left and mix_right then carry the frame sums, including the last slot's contribution, and the next frame starts from zero.
- R5: Each addition clamps the running sum to the range −32768..32767.
- R6: A slot with slot_en low adds nothing to either sum, but it still advances the slot counter.
- R7: While the sounding flag is clear, no slot adds anything, but slots still advance the counter. The flag is clear after reset.
- R8: A cycle with snd_wr high and snd_val low clears the flag and zeroes both sums. It also discards a contribution taken on the previous edge that has not yet been added. A cycle with snd_wr and snd_val both high sets the flag. The flag value used for a slot is the value held before that cycle's write.
- R9: After reset, mix_valid is low and mix_left and mix_right read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snd_wr | input | 1 | Write strobe for the sounding flag |
| snd_val | input | 1 | Flag value written when snd_wr is high |
| slot_valid | input | 1 | A voice slot is presented this cycle |
| slot_en | input | 1 | Voice enabled for this slot |
| slot_sample | input | 8 | Sign-magnitude sample (bit 7 set = positive) |
| slot_env | input | 8 | Unsigned envelope multiplier |
| slot_pan | input | 8 | Left gain in [7:4], right gain in [3:0] |
| mix_valid | output | 1 | One-cycle strobe with a finished stereo pair |
| mix_left | output | 16 | Left sum, two's complement, held until the next pair |
| mix_right | output | 16 | Right sum, two's complement, held until the next pair |

## Verification
The assertions assume that no sounding-flag write falls in the same cycle as a slot. They also assume that no flag-clear write lands on the edge where the last slot of a frame is being added. Otherwise the discard rule and the frame-completion strobe would meet in one cycle. The bench keeps to these assumptions: it issues writes only in cycles with slot_valid low. The one clear it places inside a frame comes directly after a middle slot, which also exercises the discard of an in-flight contribution. Slots may arrive back to back or with gaps; the behavioural model in the bench follows both cases.

// File: rtl/pcm_mix_pkg.sv
package pcm_mix_pkg;
  localparam int unsigned DEF_NUM_CH   = 8;
  localparam int unsigned DEF_SAMPLE_W = 8;
  localparam int unsigned DEF_ENV_W    = 8;
  localparam int unsigned DEF_GAIN_W   = 4;
  localparam int unsigned DEF_SHIFT    = 5;
  localparam int unsigned DEF_ACC_W    = 16;
  localparam int unsigned NUM_SIDES    = 2;

  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } mix_side_e;
endpackage

// File: rtl/mix_rst_sync.sv
module mix_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mix_chan_seq.sv
module mix_chan_seq #(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned CNT_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_valid,
  input  logic snd_wr,
  input  logic snd_val,
  output logic sounding,
  output logic slot_last,
  output logic clear_req
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             snd_q, snd_d;

  always_comb begin
    slot_last = (cnt_q == CNT_W'(NUM_CH - 1));
    cnt_d     = cnt_q;
    if (slot_valid) begin
      cnt_d = slot_last ? '0 : cnt_q + 1'b1;
    end
    snd_d     = snd_wr ? snd_val : snd_q;
    clear_req = snd_wr & ~snd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      snd_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      snd_q <= snd_d;
    end
  end

  assign sounding = snd_q;

  // R4
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(slot_valid && slot_last) |-> (cnt_q == '0));

  // R8
  flag_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(snd_wr) |-> (sounding == $past(snd_val)));
endmodule

// File: rtl/mix_scale.sv
module mix_scale
  import pcm_mix_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned ENV_W    = 8,
  parameter int unsigned GAIN_W   = 4,
  parameter int unsigned SHIFT    = 5,
  localparam int unsigned MAG_W   = SAMPLE_W - 1,
  localparam int unsigned BASE_W  = MAG_W + ENV_W,
  localparam int unsigned PROD_W  = BASE_W + GAIN_W,
  localparam int unsigned SP_W    = PROD_W + 1,
  localparam int unsigned OUT_W   = SP_W - SHIFT,
  localparam int unsigned PAN_W   = NUM_SIDES * GAIN_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clr,
  input  logic                             in_valid,
  input  logic                             in_last,
  input  logic                             active,
  input  logic [SAMPLE_W-1:0]              sample,
  input  logic [ENV_W-1:0]                 env,
  input  logic [PAN_W-1:0]                 pan,
  output logic                             out_valid,
  output logic                             out_last,
  output logic [NUM_SIDES-1:0][OUT_W-1:0]  contrib
);
  logic              positive;
  logic [MAG_W-1:0]  mag;
  logic [BASE_W-1:0] base;

  logic [NUM_SIDES-1:0][OUT_W-1:0] contrib_d, contrib_q;
  logic                            vld_d, vld_q;
  logic                            last_d, last_q;

  always_comb begin
    positive = sample[SAMPLE_W-1];
    mag      = sample[MAG_W-1:0];
    base     = {{ENV_W{1'b0}}, mag} * {{MAG_W{1'b0}}, env};
  end

  for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
    logic [GAIN_W-1:0]      gain;
    logic [PROD_W-1:0]      prod;
    logic signed [SP_W-1:0] sprod;

    always_comb begin
      // left gain occupies the upper nibble, right gain the lower nibble
      gain  = pan[(NUM_SIDES - g) * GAIN_W - 1 -: GAIN_W];
      prod  = {{GAIN_W{1'b0}}, base} * {{BASE_W{1'b0}}, gain};
      sprod = positive ? $signed({1'b0, prod}) : -$signed({1'b0, prod});
      contrib_d[g] = active ? OUT_W'(sprod >>> SHIFT) : '0;
    end
  end

  always_comb begin
    vld_d  = in_valid;
    last_d = in_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
    end else if (clr) begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      last_q <= last_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      contrib_q <= '0;
    end else if (in_valid) begin
      contrib_q <= contrib_d;
    end
  end

  assign out_valid = vld_q;
  assign out_last  = last_q;
  assign contrib   = contrib_q;

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && !active) |-> (contrib_q == '0));

  // R1
  pos_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && active && sample[SAMPLE_W-1]) |->
      (!contrib_q[SIDE_LEFT][OUT_W-1] && !contrib_q[SIDE_RIGHT][OUT_W-1]));
endmodule

// File: rtl/mix_accum.sv
module mix_accum #(
  parameter int unsigned IN_W  = 15,
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add_v,
  input  logic             add_last,
  input  logic [IN_W-1:0]  add_val,
  output logic [ACC_W-1:0] sum_o
);
  localparam logic [ACC_W-1:0] MAX_V = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MIN_V = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W-1:0] res_q, res_d;
  logic [ACC_W:0]   wide;
  logic [ACC_W-1:0] sat;
  logic             acc_en, res_en;

  always_comb begin
    wide = {acc_q[ACC_W-1], acc_q}
         + {{(ACC_W+1-IN_W){add_val[IN_W-1]}}, add_val};
    if (wide[ACC_W] != wide[ACC_W-1]) sat = wide[ACC_W] ? MIN_V : MAX_V;
    else                              sat = wide[ACC_W-1:0];

    acc_en = clr | add_v;
    acc_d  = (clr | add_last) ? '0 : sat;
    res_en = add_v & add_last & ~clr;
    res_d  = sat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  assign sum_o = res_q;

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (acc_q == '0));

  // R5
  no_wrap_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(add_v && !clr && !acc_q[ACC_W-1] && !add_val[IN_W-1]) |->
      (!acc_q[ACC_W-1] && (!$past(add_last) || !res_q[ACC_W-1])));

  // R5
  no_wrap_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(add_v && !clr && !add_last && acc_q[ACC_W-1] && add_val[IN_W-1]) |->
      acc_q[ACC_W-1]);
endmodule

// File: rtl/pcm_stereo_mixer.sv
module pcm_stereo_mixer
  import pcm_mix_pkg::*;
#(
  parameter int unsigned NUM_CH   = DEF_NUM_CH,
  parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
  parameter int unsigned ENV_W    = DEF_ENV_W,
  parameter int unsigned GAIN_W   = DEF_GAIN_W,
  parameter int unsigned SHIFT    = DEF_SHIFT,
  parameter int unsigned ACC_W    = DEF_ACC_W,
  localparam int unsigned PAN_W   = NUM_SIDES * GAIN_W,
  localparam int unsigned CTR_W   = SAMPLE_W - 1 + ENV_W + GAIN_W + 1 - SHIFT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                snd_wr,
  input  logic                snd_val,
  input  logic                slot_valid,
  input  logic                slot_en,
  input  logic [SAMPLE_W-1:0] slot_sample,
  input  logic [ENV_W-1:0]    slot_env,
  input  logic [PAN_W-1:0]    slot_pan,
  output logic                mix_valid,
  output logic [ACC_W-1:0]    mix_left,
  output logic [ACC_W-1:0]    mix_right
);
  logic rst_sync_n;
  logic sounding, slot_last, clear_req;
  logic st_valid, st_last;
  logic [NUM_SIDES-1:0][CTR_W-1:0] st_contrib;
  logic [NUM_SIDES-1:0][ACC_W-1:0] side_sum;
  logic mv_q, mv_d;

  mix_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mix_chan_seq #(.NUM_CH(NUM_CH)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .slot_valid (slot_valid),
    .snd_wr     (snd_wr),
    .snd_val    (snd_val),
    .sounding   (sounding),
    .slot_last  (slot_last),
    .clear_req  (clear_req)
  );

  mix_scale #(
    .SAMPLE_W (SAMPLE_W),
    .ENV_W    (ENV_W),
    .GAIN_W   (GAIN_W),
    .SHIFT    (SHIFT)
  ) u_scale (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr       (clear_req),
    .in_valid  (slot_valid),
    .in_last   (slot_last),
    .active    (sounding & slot_en),
    .sample    (slot_sample),
    .env       (slot_env),
    .pan       (slot_pan),
    .out_valid (st_valid),
    .out_last  (st_last),
    .contrib   (st_contrib)
  );

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_acc
    mix_accum #(.IN_W(CTR_W), .ACC_W(ACC_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .clr      (clear_req),
      .add_v    (st_valid),
      .add_last (st_last),
      .add_val  (st_contrib[s]),
      .sum_o    (side_sum[s])
    );
  end

  always_comb begin
    mv_d = st_valid & st_last & ~clear_req;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) mv_q <= 1'b0;
    else             mv_q <= mv_d;
  end

  assign mix_valid = mv_q;
  assign mix_left  = side_sum[SIDE_LEFT];
  assign mix_right = side_sum[SIDE_RIGHT];

  // R4
  strobe_origin_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mix_valid |-> $past(slot_valid, 2));

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mix_valid |=> !mix_valid);

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (!mix_valid && mix_left == '0 && mix_right == '0));
endmodule

// File: tb/pcm_stereo_mixer_tb.sv
module pcm_stereo_mixer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        snd_wr, snd_val, slot_valid, slot_en;
  logic [7:0]  slot_sample, slot_env, slot_pan;
  logic        mix_valid;
  logic [15:0] mix_left, mix_right;

  int checks = 0;
  int fails  = 0;
  string tag = "R9";

  always #2 clk = ~clk;

  pcm_stereo_mixer u_dut (
    .clk(clk), .rst_n(rst_n), .snd_wr(snd_wr), .snd_val(snd_val),
    .slot_valid(slot_valid), .slot_en(slot_en), .slot_sample(slot_sample),
    .slot_env(slot_env), .slot_pan(slot_pan), .mix_valid(mix_valid),
    .mix_left(mix_left), .mix_right(mix_right)
  );

  // behavioural reference model
  int m_acc_l, m_acc_r, m_out_l, m_out_r, m_cnt;
  bit m_flag, m_valid, p_v, p_last;
  int p_l, p_r;
  bit model_on = 0;

  function automatic int clamp16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int floordiv32(int v);
    if (v >= 0) return v / 32;
    return -((-v + 31) / 32);
  endfunction

  always @(posedge clk) begin
    if (!model_on) begin
      m_acc_l = 0; m_acc_r = 0; m_out_l = 0; m_out_r = 0; m_cnt = 0;
      m_flag = 0; m_valid = 0; p_v = 0; p_last = 0; p_l = 0; p_r = 0;
    end else begin
      bit old_flag;
      old_flag = m_flag;
      m_valid = 0;
      if (snd_wr && !snd_val) begin
        m_acc_l = 0; m_acc_r = 0; p_v = 0; m_flag = 0;
      end else begin
        if (snd_wr) m_flag = 1;
        if (p_v) begin
          int sl, sr;
          sl = clamp16(m_acc_l + p_l);
          sr = clamp16(m_acc_r + p_r);
          if (p_last) begin
            m_out_l = sl; m_out_r = sr; m_valid = 1; m_acc_l = 0; m_acc_r = 0;
          end else begin
            m_acc_l = sl; m_acc_r = sr;
          end
        end
        p_v = 0;
      end
      if (slot_valid) begin
        int val;
        val = slot_sample[7] ? int'(slot_sample[6:0]) : -int'(slot_sample[6:0]);
        val = val * int'(slot_env);
        p_v = 1;
        p_last = (m_cnt == 7);
        if (old_flag && slot_en) begin
          p_l = floordiv32(val * int'(slot_pan[7:4]));
          p_r = floordiv32(val * int'(slot_pan[3:0]));
        end else begin
          p_l = 0; p_r = 0;
        end
        m_cnt = (m_cnt + 1) % 8;
      end
    end
  end

  int cap_l, cap_r, cap_n;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      chk(mix_valid == m_valid, {tag, " strobe"}, int'(mix_valid), int'(m_valid));
      if (m_valid) begin
        chk($signed(mix_left) == m_out_l, {tag, " left"}, int'($signed(mix_left)), m_out_l);
        chk($signed(mix_right) == m_out_r, {tag, " right"}, int'($signed(mix_right)), m_out_r);
      end
      if (mix_valid) begin
        cap_l = int'($signed(mix_left));
        cap_r = int'($signed(mix_right));
        cap_n++;
      end
    end
  end

  task automatic slot(input bit en, input logic [7:0] s, input logic [7:0] e, input logic [7:0] p);
    slot_valid = 1; slot_en = en; slot_sample = s; slot_env = e; slot_pan = p;
    @(negedge clk);
    slot_valid = 0; slot_en = 0;
  endtask

  task automatic sound(input bit v);
    snd_wr = 1; snd_val = v;
    @(negedge clk);
    snd_wr = 0;
  endtask

  task automatic frame_one(input logic [7:0] s, input logic [7:0] e, input logic [7:0] p);
    slot(1, s, e, p);
    for (int i = 1; i < 8; i++) slot(0, 8'hFF, 8'hFF, 8'hFF);
    repeat (3) @(negedge clk);
  endtask

  task automatic frame_same(input logic [7:0] s, input logic [7:0] e, input logic [7:0] p);
    for (int i = 0; i < 8; i++) slot(1, s, e, p);
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_pair(input string req, input int l, input int r, input int n0);
    chk(cap_n == n0 + 1, {req, " one strobe"}, cap_n - n0, 1);
    chk(cap_l == l, {req, " left sum"}, cap_l, l);
    chk(cap_r == r, {req, " right sum"}, cap_r, r);
  endtask

  task automatic main_seq();
    int n0;
    rst_n = 0; snd_wr = 0; snd_val = 0; slot_valid = 0; slot_en = 0;
    slot_sample = 0; slot_env = 0; slot_pan = 0; cap_n = 0; cap_l = 0; cap_r = 0;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(!mix_valid && mix_left == 0 && mix_right == 0, "R9 reset outputs",
        int'(mix_left) + int'(mix_right) + int'(mix_valid), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    model_on = 1;
    chk(!mix_valid && mix_left == 0, "R9 after release", int'(mix_left), 0);

    // R7: flag clear after reset, nothing is added
    tag = "R7"; n0 = cap_n;
    frame_same(8'hFF, 8'hFF, 8'hFF);
    expect_pair("R7 not sounding after reset", 0, 0, n0);

    sound(1);
    // R1 R3 R6: +5 * 10 = 50, gains 3 and 1, other slots disabled
    tag = "R1"; n0 = cap_n;
    frame_one(8'h85, 8'd10, 8'h31);
    expect_pair("R1 R3 R6 positive sample", 4, 1, n0);

    // R1 R3: bit7 clear -> -50, floor division gives -5 and -2
    n0 = cap_n;
    frame_one(8'h05, 8'd10, 8'h31);
    expect_pair("R1 R3 negative sample", -5, -2, n0);

    // R2 R4: +16 * 4 = 64, gains 2 and 1, eight voices -> 32, 16
    tag = "R4"; n0 = cap_n;
    frame_same(8'h90, 8'd4, 8'h21);
    expect_pair("R2 R4 full frame", 32, 16, n0);

    // R2: envelope 0 kills the voice
    n0 = cap_n;
    frame_one(8'hFF, 8'd0, 8'hFF);
    expect_pair("R2 zero envelope", 0, 0, n0);

    // R5 saturation in both directions
    tag = "R5"; n0 = cap_n;
    frame_same(8'hFF, 8'hFF, 8'hFF);
    expect_pair("R5 positive clamp", 32767, 32767, n0);
    n0 = cap_n;
    frame_same(8'h7F, 8'hFF, 8'hF0);
    expect_pair("R5 negative clamp", -32768, 0, n0);

    // R4: next frame starts from zero after a clamped one
    tag = "R4"; n0 = cap_n;
    frame_one(8'h85, 8'd10, 8'h31);
    expect_pair("R4 restart from zero", 4, 1, n0);

    // R8: clear mid-frame, right after slot 4 (its contribution is in flight)
    tag = "R8"; n0 = cap_n;
    for (int i = 0; i < 4; i++) slot(1, 8'hFF, 8'hFF, 8'hFF);
    sound(0);
    sound(1);
    for (int i = 0; i < 4; i++) slot(1, 8'h90, 8'd4, 8'h21);
    repeat (3) @(negedge clk);
    expect_pair("R8 clear discards partial frame", 16, 8, n0);

    // R7: clearing the flag stops mixing, counter keeps going
    sound(0);
    tag = "R7"; n0 = cap_n;
    frame_same(8'hC0, 8'd50, 8'h77);
    expect_pair("R7 silent while off", 0, 0, n0);
    sound(1);

    // random frames with gaps, checked against the model each cycle
    tag = "R4 R5 R6 random";
    for (int f = 0; f < 40; f++) begin
      for (int i = 0; i < 8; i++) begin
        slot(1'($urandom_range(0, 3) != 0), 8'($urandom), 8'($urandom), 8'($urandom));
        if ($urandom_range(0, 3) == 0) @(negedge clk);
      end
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (50000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule